// File: doc/BRIEF.md
# Shared Permutation Core Phase Mux

This block lets three consumers share a single external permutation engine that works on a 1600-bit state over 24 rounds. The three consumers are a fixed-length hash unit, a uniform matrix sampler and a centered binomial noise sampler. They never run at the same time, because a 2-bit phase code from the top-level sequencer picks which one is active. For that reason the block does no arbitration.

The mux forwards the active consumer's state word and start strobe to the engine. The engine's result state goes back to every consumer on one shared bus. The engine's completion strobe goes only to the active consumer.

An idle consumer may latch the shared result bus as often as it likes. Its completion strobe stays low, so it never acts on what it latched.

A 1-bit busy register tracks whether a permutation is in flight. A sticky error flag records two kinds of misuse:
- a phase change while a permutation is in flight;
- a start strobe from a consumer that is not selected.

Top module: `shared_perm_mux`

## Requirements
- R1: Phase code 0 selects the hash unit, 1 the matrix sampler and 2 the noise sampler. The selected consumer's state word appears combinationally on the engine state input. Phase code 3 (idle) drives that bus to all zeros.
- R2: The engine start strobe equals the start strobe of the consumer selected by the phase, in the same cycle. In phase 3 it is forced low.
- R3: The engine completion strobe is copied in the same cycle to the completion output of the selected consumer only. The other two completion outputs stay low. In phase 3 all three stay low.
- R4: The engine result state is presented unchanged on the shared result output in every phase, including idle.
- R5: Busy goes high on the edge after a forwarded start. It goes low on the edge after an engine completion that coincides with no forwarded start. When a completion and a start coincide, the start wins and busy stays high.
- R6: If the phase input differs from its value at the previous edge while busy is high, the error flag rises on the next edge. The flag then stays high until reset.
- R7: A start strobe from a non-selected consumer (any start while in phase 3) is not forwarded and leaves busy unchanged. It sets the sticky error flag on the next edge.
- R8: Reset (active-low, synchronous) clears busy and the error flag and takes the remembered phase to idle. Moving from idle to any phase straight after reset is therefore not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | 2 | Active consumer: 0 hash, 1 matrix, 2 noise, 3 idle |
| hash_state_i | input | STATE_W | Hash unit state word |
| hash_start_i | input | 1 | Hash unit start strobe |
| mat_state_i | input | STATE_W | Matrix sampler state word |
| mat_start_i | input | 1 | Matrix sampler start strobe |
| noise_state_i | input | STATE_W | Noise sampler state word |
| noise_start_i | input | 1 | Noise sampler start strobe |
| eng_state_o | output | STATE_W | State word to the permutation engine |
| eng_start_o | output | 1 | Start strobe to the permutation engine |
| eng_state_i | input | STATE_W | Result state from the permutation engine |
| eng_done_i | input | 1 | Completion strobe from the permutation engine |
| res_state_o | output | STATE_W | Result state shared with all consumers |
| hash_done_o | output | 1 | Completion strobe to the hash unit |
| mat_done_o | output | 1 | Completion strobe to the matrix sampler |
| noise_done_o | output | 1 | Completion strobe to the noise sampler |
| busy_o | output | 1 | A permutation is in flight |
| err_o | output | 1 | Sticky phase-consistency error |

## Verification
The bench sweeps all four phase codes against every combination of the three start strobes and the completion strobe.

- A routing slip shows up in this sweep: a design that decodes the phase wrongly either sends another consumer's word to the engine or lets a completion leak to an idle sampler.
- Idle is checked on its own. A design that treats code 3 as a consumer would start the engine or drive a stale word.

Sequential cases go after the subtler failures:
- a completion and a new start in the same cycle, which a design with the wrong priority would leave idle;
- a phase hop during a permutation;
- a stray start from an unselected sampler;
- an idle-to-active move straight after reset.

A flag that is not sticky, or a remembered phase that resets to the wrong code, fails these cases.

// File: rtl/shared_perm_mux.sv
module shared_perm_mux #(
  parameter int STATE_W = 1600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         phase_i,
  input  logic [STATE_W-1:0] hash_state_i,
  input  logic               hash_start_i,
  input  logic [STATE_W-1:0] mat_state_i,
  input  logic               mat_start_i,
  input  logic [STATE_W-1:0] noise_state_i,
  input  logic               noise_start_i,
  output logic [STATE_W-1:0] eng_state_o,
  output logic               eng_start_o,
  input  logic [STATE_W-1:0] eng_state_i,
  input  logic               eng_done_i,
  output logic [STATE_W-1:0] res_state_o,
  output logic               hash_done_o,
  output logic               mat_done_o,
  output logic               noise_done_o,
  output logic               busy_o,
  output logic               err_o
);

  localparam logic [1:0] PH_HASH  = 2'd0;
  localparam logic [1:0] PH_MAT   = 2'd1;
  localparam logic [1:0] PH_NOISE = 2'd2;
  localparam logic [1:0] PH_IDLE  = 2'd3;

  logic [1:0] phase_q;
  logic       busy_q, err_q;

  wire sel_h = (phase_i == PH_HASH);
  wire sel_m = (phase_i == PH_MAT);
  wire sel_n = (phase_i == PH_NOISE);

  always_comb begin
    case (phase_i)
      PH_HASH:  eng_state_o = hash_state_i;
      PH_MAT:   eng_state_o = mat_state_i;
      PH_NOISE: eng_state_o = noise_state_i;
      default:  eng_state_o = '0;
    endcase
  end

  assign eng_start_o  = (sel_h & hash_start_i) | (sel_m & mat_start_i) | (sel_n & noise_start_i);
  assign res_state_o  = eng_state_i;
  assign hash_done_o  = sel_h & eng_done_i;
  assign mat_done_o   = sel_m & eng_done_i;
  assign noise_done_o = sel_n & eng_done_i;

  wire stray = (hash_start_i & ~sel_h) | (mat_start_i & ~sel_m) | (noise_start_i & ~sel_n);
  wire hop   = busy_q & (phase_i != phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_i;
      if (eng_start_o)     busy_q <= 1'b1;
      else if (eng_done_i) busy_q <= 1'b0;
      if (stray | hop)     err_q  <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

endmodule

// File: rtl/shared_perm_mux_chk.sv
module shared_perm_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase_i,
  input logic       hash_start_i,
  input logic       eng_start_o,
  input logic       eng_done_i,
  input logic       hash_done_o,
  input logic       mat_done_o,
  input logic       noise_done_o,
  input logic       busy_o,
  input logic       err_o
);

  a_r2_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 2'd3) |-> !eng_start_o);

  a_r3_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hash_done_o, mat_done_o, noise_done_o}));

  a_r3_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_done_o | mat_done_o | noise_done_o) |-> eng_done_i);

  a_r5_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> busy_o);

  a_r5_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done_i && !eng_start_o) |=> !busy_o);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  a_r7_stray_hash: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_start_i && phase_i != 2'd0) |=> err_o);

endmodule

bind shared_perm_mux shared_perm_mux_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase_i      (phase_i),
  .hash_start_i (hash_start_i),
  .eng_start_o  (eng_start_o),
  .eng_done_i   (eng_done_i),
  .hash_done_o  (hash_done_o),
  .mat_done_o   (mat_done_o),
  .noise_done_o (noise_done_o),
  .busy_o       (busy_o),
  .err_o        (err_o)
);

// File: tb/shared_perm_mux_tb_top.sv
`timescale 1ns/1ps
module shared_perm_mux_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] phase = 2'd3;
  logic [W-1:0] hs = 8'hA1, ms = 8'hB2, ns = 8'hC3, es = '0;
  logic hst = 0, mst = 0, nst = 0, edn = 0;
  logic [W-1:0] eso, rso;
  logic est, hd, md, nd, busy, err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  shared_perm_mux #(.STATE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase),
    .hash_state_i(hs), .hash_start_i(hst),
    .mat_state_i(ms), .mat_start_i(mst),
    .noise_state_i(ns), .noise_start_i(nst),
    .eng_state_o(eso), .eng_start_o(est),
    .eng_state_i(es), .eng_done_i(edn),
    .res_state_o(rso), .hash_done_o(hd), .mat_done_o(md), .noise_done_o(nd),
    .busy_o(busy), .err_o(err)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; phase = 2'd3; {hst, mst, nst, edn} = '0;
    @(posedge clk); #1;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R8 busy after reset", W'(busy), 0);
    chk("R8 err after reset", W'(err), 0);

    // Combinational sweep: phase x starts x done
    for (int ph = 0; ph < 4; ph++)
      for (int st = 0; st < 8; st++)
        for (int dn = 0; dn < 2; dn++) begin
          @(negedge clk);
          phase = 2'(ph);
          {nst, mst, hst} = 3'(st);
          edn = 1'(dn);
          es = 8'(ph * 40 + st * 3 + dn);
          #1;
          chk("R1 state forward", eso,
              ph == 0 ? hs : ph == 1 ? ms : ph == 2 ? ns : 8'h00);
          chk("R2 start forward", W'(est), W'(ph < 3 ? st[ph] : 1'b0));
          chk("R3 done routing", W'({nd, md, hd}), W'(dn ? (ph < 3 ? (3'b001 << ph) : 3'b000) : 3'b000));
          chk("R4 result broadcast", rso, 8'(ph * 40 + st * 3 + dn));
        end

    // R8: idle -> active right after reset, no error
    do_reset();
    phase = 2'd1; tick();
    chk("R8 first phase no err", W'(err), 0);
    // R5: start sets busy
    @(negedge clk); mst = 1; tick();
    chk("R5 busy set", W'(busy), 1);
    @(negedge clk); mst = 0; tick(); tick();
    chk("R5 busy holds", W'(busy), 1);
    @(negedge clk); edn = 1; #1;
    chk("R3 done to matrix", W'({nd, md, hd}), W'(3'b010));
    tick();
    chk("R5 busy cleared", W'(busy), 0);
    @(negedge clk); edn = 0; phase = 2'd2; tick();
    chk("R6 idle phase change ok", W'(err), 0);
    // R5: coincident start and done -> busy stays set
    @(negedge clk); nst = 1; edn = 1; tick();
    chk("R5 start wins", W'(busy), 1);
    @(negedge clk); nst = 0; edn = 0; tick();
    chk("R6 no err yet", W'(err), 0);
    // R6: hop while busy
    @(negedge clk); phase = 2'd0; tick();
    chk("R6 hop sets err", W'(err), 1);
    @(negedge clk); edn = 1; tick();
    @(negedge clk); edn = 0; tick(); tick();
    chk("R6 err sticky", W'(err), 1);
    do_reset(); #1;
    chk("R8 reset clears err", W'(err), 0);

    // R7: stray start from matrix sampler while hash phase
    @(negedge clk); phase = 2'd0; tick();
    @(negedge clk); mst = 1; #1;
    chk("R7 stray not forwarded", W'(est), 0);
    tick();
    chk("R7 stray busy unchanged", W'(busy), 0);
    chk("R7 stray sets err", W'(err), 1);
    @(negedge clk); mst = 0;
    // R7: start in idle
    do_reset();
    @(negedge clk); hst = 1; #1;
    chk("R7 idle start blocked", W'(est), 0);
    tick();
    chk("R7 idle start err", W'(err), 1);
    chk("R7 idle start busy", W'(busy), 0);
    @(negedge clk); hst = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule